// File: doc/BRIEF.md
# Address-Sequence Command Detector

This block watches the access stream of a small byte-wide memory and looks for a hidden command made of ordinary reads. Each access is counted once, when the synchronised chip-enable input goes low. A fixed prefix of five read addresses, given in hex as 000, 555, 2AA, 7FF and 0F0, followed by a sixth read, forms a command. The sixth address selects the command: 70F asks for a store and 70E asks for a recall. The block does not move any data. It issues a one-cycle pulse on `store_cmd` or `recall_cmd`, which the surrounding transfer engine acts on.

A write anywhere in the pattern cancels the match, and so does a read that is out of order. The output-enable level plays no part, so the block has no input for it. While the supply is below the switch threshold, `store_inhibit` is high and blocks store commands. Recall commands still pass. A read of address 000 always counts as the first step of a new attempt. The memory itself answers all six reads as normal reads, and this block never stalls them. The current progress through the pattern is reported on `seq_step`.

Top module: `acd_cmd_detect`

## Requirements
- R1: After reset, `seq_step` is 0 and both `store_cmd` and `recall_cmd` are low.
- R2: Reads of 000, 555, 2AA, 7FF, 0F0 and then 70F, with `store_inhibit` low at the sixth read, raise `store_cmd` for exactly one cycle. The pulse appears in the cycle after the third rising clock edge that follows chip enable going low. `seq_step` returns to 0 in that same cycle.
- R3: The same five-read prefix followed by a read of 70E raises `recall_cmd` for exactly one cycle, with the same timing as R2. `seq_step` returns to 0.
- R4: If `store_inhibit` is high at the sixth read of 70F, no store command is issued and `seq_step` returns to 0. `store_inhibit` has no effect on a recall.
- R5: An access with `we_n` low (a write) sets `seq_step` to 0 and issues no command, whatever the address and whatever the step.
- R6: A read whose address is neither the next expected one nor 000 sets `seq_step` to 0 and issues no command. This includes a sixth read that is neither 70F nor 70E.
- R7: A read of 000 sets `seq_step` to 1 from any step, including step 5.
- R8: Each falling edge of the synchronised chip enable counts as exactly one access. A matching read moves `seq_step` from k to k+1, for k from 0 to 4. Holding chip enable low for a longer time adds no further step and no command.
- R9: `store_cmd` and `recall_cmd` are never high together. Each stays high for a single cycle only.
- R10: `seq_step` never exceeds 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable from the bus, active low, asynchronous to `clk` |
| we_n | input | 1 | Write enable, low marks a write. Sampled at the access event |
| addr | input | ADDR_W | Access address. Sampled at the access event |
| store_inhibit | input | 1 | High while the supply is below the switch threshold, blocks store |
| store_cmd | output | 1 | One-cycle store request |
| recall_cmd | output | 1 | One-cycle recall request |
| seq_step | output | 3 | Number of prefix reads matched so far (0 to 5) |

## Verification
The bench builds the block with its default parameters. The address is 11 bits wide, the synchroniser has two stages, and the keys are the six listed above. With these values every key sits among the full 2048 addresses, and the store key and the recall key differ only in bit 0, so random near-misses really do occur. A random walk mostly follows the expected next key and sometimes makes a write, an off-key read or an early read of 000. With `store_inhibit` also chosen at random, completed store attempts, inhibited store attempts, recall attempts and aborted attempts all appear many times. The latency of three clock edges is fixed by the two-stage synchroniser, so the bench samples every result in one known cycle.

// File: rtl/acd_pkg.sv
package acd_pkg;

    // Number of fixed addresses that come before the selecting access
    localparam int PREFIX_LEN = 5;
    localparam int STEP_W     = 3;

    typedef enum logic [STEP_W-1:0] {
        ST_IDLE = 3'd0,
        ST_K1   = 3'd1,
        ST_K2   = 3'd2,
        ST_K3   = 3'd3,
        ST_K4   = 3'd4,
        ST_K5   = 3'd5
    } step_e;

    typedef struct packed {
        step_e step;
        logic  store;
        logic  recall;
    } seq_state_t;

endpackage

// File: rtl/acd_ce_edge.sv
module acd_ce_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n_async,
    output logic access_ev
);

    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] sync_d, sync_q;
    logic         prev_d, prev_q;

    always_comb begin
        sync_d = {sync_q[MSB-1:0], ce_n_async};
        prev_d = sync_q[MSB];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    // One event per falling edge of the synchronised enable
    assign access_ev = prev_q & ~sync_q[MSB];

    // R8: an event never lasts more than one cycle
    p_single_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
        access_ev |=> !access_ev);

endmodule

// File: rtl/acd_key_match.sv
module acd_key_match
    import acd_pkg::*;
#(
    parameter int              ADDR_W = 11,
    parameter logic [ADDR_W-1:0] PREFIX_KEYS [PREFIX_LEN] =
        '{11'h000, 11'h555, 11'h2AA, 11'h7FF, 11'h0F0},
    parameter logic [ADDR_W-1:0] STORE_KEY  = 11'h70F,
    parameter logic [ADDR_W-1:0] RECALL_KEY = 11'h70E
) (
    input  logic [ADDR_W-1:0]     addr,
    output logic [PREFIX_LEN-1:0] prefix_hit,
    output logic                  store_hit,
    output logic                  recall_hit
);

    for (genvar i = 0; i < PREFIX_LEN; i++) begin : g_key
        assign prefix_hit[i] = (addr == PREFIX_KEYS[i]);
    end

    assign store_hit  = (addr == STORE_KEY);
    assign recall_hit = (addr == RECALL_KEY);

    // A single address can match at most one prefix key
    always_comb begin
        a_prefix_unique_r6: assert ($onehot0(prefix_hit) || $isunknown(addr));
    end

endmodule

// File: rtl/acd_sequencer.sv
module acd_sequencer
    import acd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  access_ev,
    input  logic                  we_n,
    input  logic                  store_inhibit,
    input  logic [PREFIX_LEN-1:0] prefix_hit,
    input  logic                  store_hit,
    input  logic                  recall_hit,
    output logic                  store_cmd,
    output logic                  recall_cmd,
    output logic [STEP_W-1:0]     seq_step
);

    seq_state_t st_d, st_q;
    logic       next_hit;

    // Does the address match the key expected at the current step?
    always_comb begin
        unique case (st_q.step)
            ST_K1:   next_hit = prefix_hit[1];
            ST_K2:   next_hit = prefix_hit[2];
            ST_K3:   next_hit = prefix_hit[3];
            ST_K4:   next_hit = prefix_hit[4];
            default: next_hit = 1'b0;
        endcase
    end

    always_comb begin
        st_d        = st_q;
        st_d.store  = 1'b0;
        st_d.recall = 1'b0;
        if (access_ev) begin
            if (!we_n) begin
                st_d.step = ST_IDLE;
            end else if (st_q.step == ST_K5) begin
                st_d.store  = store_hit & ~store_inhibit;
                st_d.recall = recall_hit;
                st_d.step   = prefix_hit[0] ? ST_K1 : ST_IDLE;
            end else if (prefix_hit[0]) begin
                st_d.step = ST_K1;
            end else if (next_hit) begin
                st_d.step = step_e'(st_q.step + 3'd1);
            end else begin
                st_d.step = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{step: ST_IDLE, store: 1'b0, recall: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign store_cmd  = st_q.store;
    assign recall_cmd = st_q.recall;
    assign seq_step   = st_q.step;

    // R9: commands are exclusive and one cycle long
    p_cmd_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({store_cmd, recall_cmd}));
    p_store_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        store_cmd |=> !store_cmd);
    p_recall_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        recall_cmd |=> !recall_cmd);
    // R10: progress stays in range
    p_step_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        seq_step <= 3'd5);
    // R2: a store only follows a completed prefix with no inhibit
    p_store_origin_r2: assert property (@(posedge clk) disable iff (!rst_n)
        store_cmd |-> ($past(seq_step) == 3'd5) && !$past(store_inhibit));
    // R3: a recall only follows a completed prefix
    p_recall_origin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        recall_cmd |-> ($past(seq_step) == 3'd5));
    // R5: a write aborts the pattern
    p_write_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (access_ev && !we_n) |=> (seq_step == 3'd0) && !store_cmd && !recall_cmd);
    // R8: no progress without an access event
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !access_ev |=> $stable(seq_step));

endmodule

// File: rtl/acd_cmd_detect.sv
module acd_cmd_detect
    import acd_pkg::*;
#(
    parameter int                ADDR_W      = 11,
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] PREFIX_KEYS [PREFIX_LEN] =
        '{11'h000, 11'h555, 11'h2AA, 11'h7FF, 11'h0F0},
    parameter logic [ADDR_W-1:0] STORE_KEY   = 11'h70F,
    parameter logic [ADDR_W-1:0] RECALL_KEY  = 11'h70E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              store_inhibit,
    output logic              store_cmd,
    output logic              recall_cmd,
    output logic [STEP_W-1:0] seq_step
);

    logic                  access_ev;
    logic [PREFIX_LEN-1:0] prefix_hit;
    logic                  store_hit;
    logic                  recall_hit;

    acd_ce_edge #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_n_async (ce_n),
        .access_ev  (access_ev)
    );

    acd_key_match #(
        .ADDR_W      (ADDR_W),
        .PREFIX_KEYS (PREFIX_KEYS),
        .STORE_KEY   (STORE_KEY),
        .RECALL_KEY  (RECALL_KEY)
    ) u_match (
        .addr       (addr),
        .prefix_hit (prefix_hit),
        .store_hit  (store_hit),
        .recall_hit (recall_hit)
    );

    acd_sequencer u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .access_ev     (access_ev),
        .we_n          (we_n),
        .store_inhibit (store_inhibit),
        .prefix_hit    (prefix_hit),
        .store_hit     (store_hit),
        .recall_hit    (recall_hit),
        .store_cmd     (store_cmd),
        .recall_cmd    (recall_cmd),
        .seq_step      (seq_step)
    );

    // R1: quiet after reset release
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (seq_step == 3'd0) && !store_cmd && !recall_cmd);

endmodule

// File: tb/acd_cmd_detect_tb.sv
module acd_cmd_detect_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1;
    logic          we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          inh = 1'b0;
    logic          store_cmd, recall_cmd;
    logic [2:0]    seq_step;

    int checks = 0;
    int fails  = 0;
    int exp_step = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acd_cmd_detect u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ce_n          (ce_n),
        .we_n          (we_n),
        .addr          (addr),
        .store_inhibit (inh),
        .store_cmd     (store_cmd),
        .recall_cmd    (recall_cmd),
        .seq_step      (seq_step)
    );

    function automatic logic [AW-1:0] key(input int i);
        case (i)
            0: key = 11'h000;
            1: key = 11'h555;
            2: key = 11'h2AA;
            3: key = 11'h7FF;
            4: key = 11'h0F0;
            5: key = 11'h70F;
            default: key = 11'h70E;
        endcase
    endfunction

    // Expected result {step, store, recall} of one access
    function automatic logic [4:0] model(input int st, input logic [AW-1:0] a,
                                         input logic w, input logic ih);
        int ns; logic s; logic r;
        s = 1'b0; r = 1'b0;
        if (!w) ns = 0;
        else if (st == 5) begin
            s  = (a == 11'h70F) && !ih;
            r  = (a == 11'h70E);
            ns = (a == 11'h000) ? 1 : 0;
        end else if (a == 11'h000) ns = 1;
        else if (st >= 1 && a == key(st)) ns = st + 1;
        else ns = 0;
        model = {ns[2:0], s, r};
    endfunction

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: got step=%0d st=%0b rc=%0b, expected step=%0d st=%0b rc=%0b",
                     req, act[4:2], act[1], act[0], expv[4:2], expv[1], expv[0]);
        end
    endtask

    // One access; hold extra cycles with chip enable low
    task automatic access(input logic [AW-1:0] a, input logic w, input logic ih,
                          input int hold, input string req);
        logic [4:0] e;
        e = model(exp_step, a, w, ih);
        @(negedge clk);
        addr = a; we_n = w; inh = ih; ce_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(req, {seq_step, store_cmd, recall_cmd}, e);
        exp_step = int'(e[4:2]);
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            check("R8 held enable", {seq_step, store_cmd, recall_cmd}, {e[4:2], 2'b00});
        end
        ce_n = 1'b1;
        repeat (3) @(posedge clk);
    endtask

    task automatic prefix(input string req);
        for (int i = 0; i < 5; i++) access(key(i), 1'b1, 1'b0, 0, req);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", {seq_step, store_cmd, recall_cmd}, 5'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 after release", {seq_step, store_cmd, recall_cmd}, 5'b0);

        // R2 store, with a cycle after the pulse checked low (R9)
        prefix("R8 prefix step");
        access(11'h70F, 1'b1, 1'b0, 1, "R2 store");
        // R3 recall, even with inhibit high (R4)
        prefix("R8 prefix step");
        access(11'h70E, 1'b1, 1'b1, 1, "R3 R4 recall under inhibit");
        // R4 store blocked
        prefix("R8 prefix step");
        access(11'h70F, 1'b1, 1'b1, 0, "R4 store inhibited");
        // R5 write in the middle, then at the sixth access
        access(11'h000, 1'b1, 1'b0, 0, "R7");
        access(11'h555, 1'b1, 1'b0, 0, "R8");
        access(11'h2AA, 1'b0, 1'b0, 0, "R5 write aborts");
        prefix("R8 prefix step");
        access(11'h70F, 1'b0, 1'b0, 0, "R5 write at sixth");
        // R6 wrong read, and wrong sixth address
        access(11'h000, 1'b1, 1'b0, 0, "R7");
        access(11'h2AA, 1'b1, 1'b0, 0, "R6 out of order");
        prefix("R8 prefix step");
        access(11'h70D, 1'b1, 1'b0, 0, "R6 bad sixth");
        // R7 restart from step 3 and from step 5
        access(11'h000, 1'b1, 1'b0, 0, "R7");
        access(11'h555, 1'b1, 1'b0, 0, "R8");
        access(11'h2AA, 1'b1, 1'b0, 0, "R8");
        access(11'h000, 1'b1, 1'b0, 0, "R7 restart mid");
        prefix("R8 prefix step");
        access(11'h000, 1'b1, 1'b0, 0, "R7 restart at step5");
        // R8 long hold counts once
        access(11'h555, 1'b1, 1'b0, 6, "R8 long hold");

        // Random walk biased toward the expected next key
        for (int n = 0; n < 600; n++) begin
            logic [AW-1:0] a; logic w; logic ih; int sel;
            sel = int'($urandom_range(0, 9));
            if (sel < 7) begin
                if (exp_step == 5) a = key(5 + int'($urandom_range(0, 1)));
                else a = key(exp_step);
            end else if (sel == 7) a = key(0);
            else a = AW'($urandom);
            w  = ($urandom_range(0, 15) != 0);
            ih = ($urandom_range(0, 3) == 0);
            access(a, w, ih, int'($urandom_range(0, 1)), "R2 R3 R4 R5 R6 R7 random");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule